// File: doc/BRIEF.md
# Reloadable Watchdog with Reset Pulse Output

This block supervises software through a periodic refresh. Two byte-wide registers sit behind a simple write/read port: a reload register and a five-bit control register. Once the start bit is set, a counter climbs from a base value built from the reload register. If software does not request a refresh in time, the counter passes its all-ones value and the block reports an overflow. The overflow sets a sticky flag and, when enabled, raises a one-cycle internal reset request. When a second enable is also set, it drives an external reset pin for a fixed number of clocks.

The register port carries single register accesses with no flow control. A write is accepted on every clock edge where `wr_en` is high, so no valid/ready handshake applies. Reads are combinational from `rd_sel`. The internal reset request returns the block's own control state to its idle values. The sticky flag is kept, so software can tell after restart that the watchdog caused the reset. Only the external `rst_n` clears everything.

Top module: `wdog_top`

## Requirements
- R1: While `rst_n` is low, and after its release, both registers read 0x00, `wd_rst_o` is low and `rst_pin_o` is low.
- R2: `wr_sel`/`rd_sel` = 0 selects the control register and 1 selects the reload register. Control bits are: bit 0 start, bit 1 refresh, bit 2 overflow flag, bit 3 reset enable, bit 4 pin enable. Bits 7:5 always read 0. The reload register reads back the value written.
- R3: Writing 1 to control bit 1 sets the refresh bit. It reads 1 for exactly one cycle and is then cleared by hardware, when the counter loads {reload, 8'h00}. A pending refresh takes priority over an overflow that would occur in the same cycle.
- R4: While running, the counter advances once per clock. Starting from {reload, 8'h00}, the overflow occurs on the (65536 - reload*256)-th clock edge after the start bit is written. Overflow reloads the counter, so the next overflow follows after the same number of edges.
- R5: While the start bit is 0, the counter keeps its value. After a restart, counting resumes from that held value.
- R6: Overflow sets the flag (bit 2). Writing 1 to bit 2 clears it and writing 0 leaves it unchanged. An overflow in the same cycle as a clearing write wins, and the flag stays 1.
- R7: `wd_rst_o` is high for exactly one cycle, in the cycle after an overflow, and only if the reset enable is 1.
- R8: `rst_pin_o` is high for exactly 32 consecutive cycles, starting with the cycle after an overflow, only if both enables are 1. A running pulse is not restarted, and the internal reset does not stop it.
- R9: In the cycle after `wd_rst_o`, the start, refresh and both enable bits, the reload register and the counter are 0. The flag keeps its value, and writes during the `wd_rst_o` cycle are ignored.
- R10: Asserting `rst_n` clears the overflow flag together with all other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External hardware reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 reload |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 control, 1 reload |
| rd_data | output | 8 | Read data (combinational) |
| wd_rst_o | output | 1 | One-cycle internal reset request |
| rst_pin_o | output | 1 | Stretched external reset pin drive |

## Verification
Two collisions are provoked in the same cycle. First, a refresh request is written on the edge where the counter reaches all-ones, so it is pending exactly when the overflow would occur. The bench judges that no reset request appears and that the next overflow arrives a full period later. Second, a write that clears the flag is timed onto the automatic-reload overflow edge, and the flag must read 1 afterwards.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int REG_W = 8;
  localparam int CTL_W = 5;

  localparam int B_START   = 0;
  localparam int B_REFRESH = 1;
  localparam int B_FLAG    = 2;
  localparam int B_RSTEN   = 3;
  localparam int B_PINEN   = 4;

  localparam logic SEL_CTRL   = 1'b0;
  localparam logic SEL_RELOAD = 1'b1;

  // packed MSB first: field order equals bit positions 4..0
  typedef struct packed {
    logic pin_en;
    logic rst_en;
    logic flag;
    logic refresh;
    logic start;
  } ctl_t;
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int RLD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             soft_clr,
  input  logic             ovf,
  output ctl_t             ctl,
  output logic [RLD_W-1:0] rld
);
  logic wr_ctl, wr_rld;
  ctl_t wr_bits;
  logic unused_hi;

  assign wr_ctl    = wr_en && (wr_sel == SEL_CTRL) && !soft_clr;
  assign wr_rld    = wr_en && (wr_sel == SEL_RELOAD) && !soft_clr;
  assign wr_bits   = ctl_t'(wr_data[CTL_W-1:0]);
  assign unused_hi = ^wr_data[REG_W-1:CTL_W];

  // plain enable bits: cleared by the internal reset, else written
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl.start  <= 1'b0;
      ctl.rst_en <= 1'b0;
      ctl.pin_en <= 1'b0;
    end else if (soft_clr) begin
      ctl.start  <= 1'b0;
      ctl.rst_en <= 1'b0;
      ctl.pin_en <= 1'b0;
    end else if (wr_ctl) begin
      ctl.start  <= wr_bits.start;
      ctl.rst_en <= wr_bits.rst_en;
      ctl.pin_en <= wr_bits.pin_en;
    end
  end

  // refresh: set by software, lasts one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl.refresh <= 1'b0;
    else if (wr_ctl) ctl.refresh <= wr_bits.refresh;
    else             ctl.refresh <= 1'b0;
  end

  // sticky flag: only rst_n or write-one clears it, overflow wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ctl.flag <= 1'b0;
    else if (ovf)                   ctl.flag <= 1'b1;
    else if (wr_ctl && wr_bits.flag) ctl.flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rld <= '0;
    else if (soft_clr) rld <= '0;
    else if (wr_rld)   rld <= wr_data[RLD_W-1:0];
  end

  always_comb begin
    if (rd_sel == SEL_RELOAD) rd_data = REG_W'(rld);
    else                      rd_data = REG_W'(ctl);
  end
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
  parameter int RLD_W = 8,
  parameter int LOW_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   reload_req,
  input  logic                   soft_clr,
  input  logic [RLD_W-1:0]       rld,
  output logic                   ovf,
  output logic [RLD_W+LOW_W-1:0] cnt
);
  localparam int CNT_W = RLD_W + LOW_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] base;
  logic             at_max;

  assign base   = {rld, {LOW_W{1'b0}}};
  assign at_max = (cnt == CNT_MAX);
  // a pending refresh or reset pre-empts the wrap
  assign ovf    = run && at_max && !reload_req && !soft_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (soft_clr)   cnt <= '0;
    else if (reload_req) cnt <= base;
    else if (run) begin
      if (at_max) cnt <= base;
      else        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
`timescale 1ns/1ps
module wdog_pulse #(
  parameter int PULSE_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pin
);
  localparam int PC_W = $clog2(PULSE_CYC + 1);
  localparam logic [PC_W-1:0] PC_LOAD = PC_W'(PULSE_CYC);

  logic [PC_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    left <= '0;
    else if (fire && left == '0)   left <= PC_LOAD;
    else if (left != '0)           left <= left - 1'b1;
  end

  assign pin = (left != '0);
endmodule

// File: rtl/wdog_top.sv
`timescale 1ns/1ps
module wdog_top
  import wdog_pkg::*;
#(
  parameter int RLD_W     = 8,
  parameter int LOW_W     = 8,
  parameter int PULSE_CYC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             wd_rst_o,
  output logic             rst_pin_o
);
  localparam int CNT_W = RLD_W + LOW_W;

  ctl_t             ctl;
  logic [RLD_W-1:0] rld;
  logic [CNT_W-1:0] cnt_val;
  logic             ovf;
  logic             wd_rst_q;
  logic             ctl_start, ctl_refresh, ctl_flag, ctl_re, ctl_oe;

  assign ctl_start   = ctl.start;
  assign ctl_refresh = ctl.refresh;
  assign ctl_flag    = ctl.flag;
  assign ctl_re      = ctl.rst_en;
  assign ctl_oe      = ctl.pin_en;

  wdog_regs #(.RLD_W(RLD_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .soft_clr(wd_rst_q), .ovf(ovf),
    .ctl(ctl), .rld(rld)
  );

  wdog_counter #(.RLD_W(RLD_W), .LOW_W(LOW_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .run(ctl_start), .reload_req(ctl_refresh), .soft_clr(wd_rst_q),
    .rld(rld), .ovf(ovf), .cnt(cnt_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_rst_q <= 1'b0;
    else        wd_rst_q <= ovf && ctl_re;
  end

  wdog_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n),
    .fire(ovf && ctl_re && ctl_oe),
    .pin(rst_pin_o)
  );

  assign wd_rst_o = wd_rst_q;
endmodule

// File: rtl/wdog_checker.sv
`timescale 1ns/1ps
module wdog_checker #(
  parameter int CNT_W     = 16,
  parameter int PULSE_CYC = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wd_rst,
  input logic             pin,
  input logic             start,
  input logic             refresh,
  input logic             flag,
  input logic             re,
  input logic             oe,
  input logic             wr_en,
  input logic             wr_sel,
  input logic             wr_bit1,
  input logic [CNT_W-1:0] cnt
);
  localparam int HL_W = $clog2(PULSE_CYC + 2);
  logic [HL_W-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_len <= '0;
    else if (pin) hi_len <= hi_len + 1'b1;
    else          hi_len <= '0;
  end

  assert_rst_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> !wd_rst);

  assert_pin_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin) |-> $past(re && oe));

  assert_pin_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin) |-> (hi_len == HL_W'(PULSE_CYC)));

  assert_refresh_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !(wr_en && !wr_sel && wr_bit1)) |=> !refresh);

  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !refresh && !wd_rst) |=> $stable(cnt));

  assert_flag_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> flag);

  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> (!start && !re && !oe && cnt == '0));
endmodule

bind wdog_top wdog_checker #(.CNT_W(RLD_W + LOW_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wd_rst(wd_rst_o), .pin(rst_pin_o),
  .start(ctl_start), .refresh(ctl_refresh), .flag(ctl_flag),
  .re(ctl_re), .oe(ctl_oe),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_bit1(wr_data[1]), .cnt(cnt_val)
);

// File: tb/tb_wdog_top.sv
`timescale 1ns/1ps
module tb_wdog_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_sel, rd_sel;
  logic [7:0] wr_data, rd_data;
  logic       wd_rst_o, rst_pin_o;
  int         n_chk = 0;
  int         n_err = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  wdog_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .wd_rst_o(wd_rst_o), .rst_pin_o(rst_pin_o)
  );

  // {sel, write data, expected read-back}
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'hE0, 8'h00},
    {1'b1, 8'hFF, 8'hFF},
    {1'b1, 8'h5A, 8'h5A},
    {1'b0, 8'h18, 8'h18},
    {1'b0, 8'h10, 8'h10},
    {1'b0, 8'h04, 8'h00},
    {1'b0, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] val);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic [7:0] r);
    wr(1'b1, r);
    wr(1'b0, 8'h02);
    idle(1);
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00; rd_sel = 1'b0;
    idle(3);
    rd(1'b0, v); chk("R1 ctrl in reset", v, 8'h00);
    rst_n = 1'b1;
    idle(1);
    rd(1'b0, v); chk("R1 ctrl after reset", v, 8'h00);
    rd(1'b1, v); chk("R1 reload after reset", v, 8'h00);
    chk("R1 outputs", {6'd0, wd_rst_o, rst_pin_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][16], VEC[i][15:8]);
      rd(VEC[i][16], v);
      chk($sformatf("R2 vector %0d", i), v, VEC[i][7:0]);
    end

    // refresh bit lifetime
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'h02);
    rd(1'b0, v); chk("R3 refresh set", v, 8'h02);
    idle(1);
    rd(1'b0, v); chk("R3 refresh self-clear", v, 8'h00);

    // A: both enables, overflow after 256 edges
    wr(1'b0, 8'h19);
    idle(255);
    rd(1'b0, v); chk("R4 no early overflow", v, 8'h19);
    chk("R7 no early reset", {7'd0, wd_rst_o}, 8'h00);
    idle(1);
    rd(1'b0, v); chk("R6 flag set", v, 8'h1D);
    chk("R7 reset request", {7'd0, wd_rst_o}, 8'h01);
    chk("R8 pin rises", {7'd0, rst_pin_o}, 8'h01);
    idle(1);
    chk("R7 one cycle", {7'd0, wd_rst_o}, 8'h00);
    rd(1'b0, v); chk("R9 ctrl after soft reset", v, 8'h04);
    rd(1'b1, v); chk("R9 reload after soft reset", v, 8'h00);
    idle(30);
    chk("R8 pin at 32nd cycle", {7'd0, rst_pin_o}, 8'h01);
    idle(1);
    chk("R8 pin ends", {7'd0, rst_pin_o}, 8'h00);
    wr(1'b0, 8'h04);
    rd(1'b0, v); chk("R6 write-one clear", v, 8'h00);

    // B: reset enable only
    arm(8'hFF);
    wr(1'b0, 8'h09);
    idle(255);
    chk("R7 before overflow", {7'd0, wd_rst_o}, 8'h00);
    idle(1);
    chk("R7 reset with re", {7'd0, wd_rst_o}, 8'h01);
    chk("R8 no pin without oe", {7'd0, rst_pin_o}, 8'h00);
    idle(1);
    rd(1'b0, v); chk("R9 flag kept", v, 8'h04);
    wr(1'b0, 8'h04);

    // C: no reset enable, auto reload, set beats clear
    arm(8'hFF);
    wr(1'b0, 8'h01);
    idle(256);
    rd(1'b0, v); chk("R6 flag without re", v, 8'h05);
    chk("R7 no reset without re", {7'd0, wd_rst_o}, 8'h00);
    wr(1'b0, 8'h05);
    rd(1'b0, v); chk("R6 cleared while running", v, 8'h01);
    idle(254);
    rd(1'b0, v); chk("R4 reload period", v, 8'h01);
    wr(1'b0, 8'h05);
    rd(1'b0, v); chk("R6 set wins over clear", v, 8'h05);
    wr(1'b0, 8'h00);
    rd(1'b0, v); chk("R6 write zero keeps flag", v, 8'h04);
    wr(1'b0, 8'h04);

    // D: stop holds the count
    arm(8'hFF);
    wr(1'b0, 8'h01);
    idle(100);
    wr(1'b0, 8'h00);
    idle(300);
    rd(1'b0, v); chk("R5 no overflow while stopped", v, 8'h00);
    wr(1'b0, 8'h01);
    idle(154);
    rd(1'b0, v); chk("R5 resume no early overflow", v, 8'h01);
    idle(1);
    rd(1'b0, v); chk("R5 resume overflow timing", v, 8'h05);
    wr(1'b0, 8'h04);

    // E: refresh on the overflow edge
    arm(8'hFF);
    wr(1'b0, 8'h09);
    idle(254);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R3 refresh pending", v, 8'h0B);
    idle(1);
    rd(1'b0, v); chk("R3 refresh beats overflow", v, 8'h09);
    chk("R3 no reset on collision", {7'd0, wd_rst_o}, 8'h00);
    idle(255);
    chk("R3 full period after refresh", {7'd0, wd_rst_o}, 8'h00);
    idle(1);
    chk("R3 overflow after refresh period", {7'd0, wd_rst_o}, 8'h01);
    idle(1);

    // G: different reload value, 512 edges
    arm(8'hFE);
    wr(1'b0, 8'h05);
    idle(511);
    rd(1'b0, v); chk("R4 reload FE early", v, 8'h01);
    idle(1);
    rd(1'b0, v); chk("R4 reload FE overflow", v, 8'h05);

    // F: external reset clears the flag
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    rd(1'b0, v); chk("R10 flag cleared by rst_n", v, 8'h00);
    rd(1'b1, v); chk("R10 reload cleared", v, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule